// File: doc/BRIEF.md
# Prescaled Input Capture Timer

A 16-bit up-counter that runs from the system clock through a power-of-two prescaler. It records the count at the moment an external input changes level. The counter starts from a value written by software. It counts up to a programmed limit, returns to 0001H and raises a reload event. A qualifying edge on the external input copies the running count into a capture register. In continue mode the counter keeps running after a capture. In restart mode the capture also forces the counter back to 0001H, so each captured value is the time since the previous edge.

Software programs the block through a small register port with four 16-bit locations. Before enabling the timer it clears the capture register to 0000H. A capture register that still holds zero after an interrupt therefore points to a reload. A status bit tells the two interrupt causes apart, and a 2-bit select field chooses which events may interrupt.

Top module: `cap_timer`

## Requirements
- R1: After reset every register reads 0000H (control word, count, limit, capture) and `irq` is low.
- R2: While enabled, the count rises by one every 2^N system clocks, where N is control bits [5:3]. With the count at 0001H and a limit of L, the first reload interrupt appears L*2^N clocks after the enabling write, and further ones follow every L*2^N clocks.
- R3: A prescaler tick with the count equal to the limit loads 0001H instead of incrementing, and raises a reload event.
- R4: Control bit [2] selects the capture edge: 0 selects rising and 1 selects falling. An edge of the other direction captures nothing and raises no interrupt.
- R5: The input passes through two synchronising flops. The capture register receives the count held just before the third rising clock edge after the input change.
- R6: Control bit [1] selects the mode. With 0 (continue) the count keeps incrementing through a capture. With 1 (restart) the count becomes 0001H at the capture edge.
- R7: Control bit [8] (read-only) is set by a capture interrupt and cleared by a reload interrupt. A capture and a reload in the same cycle count as a capture.
- R8: Control bits [7:6] select the interrupt sources: 00 or 11 selects both, 01 selects capture only, 10 selects reload only. A filtered-out capture still loads the capture register.
- R9: `irq` is a registered pulse, high for one cycle in the cycle after the event.
- R10: Writes to the count location (address 1) are ignored while control bit [0] (enable) is set, and are taken while it is clear. The capture location (address 3) is writable.
- R11: With the enable bit clear, the count holds its value and the prescaler is cleared, so a new enable always begins a full prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 count, 2 limit, 3 capture |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| tmr_in | input | 1 | External capture input, asynchronous |
| irq | output | 1 | Interrupt pulse |

## Verification
The embedded assertions check on every cycle that:
- a capture copies the previous count;
- restart mode lands on 0001H;
- a disabled counter is frozen;
- a simultaneous capture and reload ends as a capture interrupt;
- prescaler ticks never come back to back at a division above one.

Only the bench scenarios can show the end-to-end latency through the synchroniser, the reload periods for each prescale setting, the edge-polarity rejection, the effect of the source filter on the status bit, and that count writes are dropped while the timer runs.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int PS_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_LIMIT  = 2'd2,
    REG_CAPT   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    IRQ_ALL     = 2'd0,
    IRQ_CAPTURE = 2'd1,
    IRQ_WRAP    = 2'd2,
    IRQ_ALL_ALT = 2'd3
  } irq_src_e;

  // bit 0 is the enable, the 2-bit source field is the top of the byte
  typedef struct packed {
    irq_src_e        src;
    logic [PS_W-1:0] presc;
    logic            falling;
    logic            restart;
    logic            en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ct_rst_sync.sv
module ct_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    mask   = (DIV_W'(1) << sel) - DIV_W'(1);
    tick   = en && ((pcnt_q & mask) == mask);
    pcnt_d = en ? pcnt_q + DIV_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R2: above divide-by-one a tick is never followed by another
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/ct_edge_det.sv
module ct_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic falling,
  output logic hit
);
  logic [SYNC:0] sh_q, sh_d;
  logic          cur, prev;

  always_comb begin
    sh_d = {sh_q[SYNC-1:0], din};
    cur  = sh_q[SYNC-1];
    prev = sh_q[SYNC];
    hit  = falling ? (prev && !cur) : (cur && !prev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             tmr_in,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             rst_s;
  ctrl_t            ctrl_q, ctrl_d;
  logic             status_q, status_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d, cap_q, cap_d;
  logic             irq_q, irq_d;
  logic             tick, hit, cap_evt, wrap_evt, cap_ok, wrap_ok;
  logic             irq_cap, irq_wrap;
  logic             wr_ctrl, wr_cnt, wr_lim, wr_cap;

  ct_rst_sync i_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s));

  ct_prescaler #(.PS_W(PS_W)) i_presc (
    .clk(clk), .rst_n(rst_s), .en(ctrl_q.en), .sel(ctrl_q.presc), .tick(tick)
  );

  ct_edge_det #(.SYNC(SYNC)) i_edge (
    .clk(clk), .rst_n(rst_s), .din(tmr_in), .falling(ctrl_q.falling), .hit(hit)
  );

  always_comb begin
    wr_ctrl  = wr_en && (addr == REG_CTRL);
    wr_cnt   = wr_en && (addr == REG_COUNT);
    wr_lim   = wr_en && (addr == REG_LIMIT);
    wr_cap   = wr_en && (addr == REG_CAPT);

    cap_evt  = ctrl_q.en && hit;
    wrap_evt = tick && (cnt_q == lim_q);
    cap_ok   = (ctrl_q.src != IRQ_WRAP);
    wrap_ok  = (ctrl_q.src != IRQ_CAPTURE);
    irq_cap  = cap_evt && cap_ok;
    irq_wrap = wrap_evt && wrap_ok;
    irq_d    = irq_cap || irq_wrap;

    ctrl_d = wr_ctrl ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    lim_d  = wr_lim ? wdata : lim_q;

    cnt_d = cnt_q;
    if (!ctrl_q.en) begin
      if (wr_cnt) cnt_d = wdata;
    end else if (cap_evt && ctrl_q.restart) begin
      cnt_d = ONE;
    end else if (wrap_evt) begin
      cnt_d = ONE;
    end else if (tick) begin
      cnt_d = cnt_q + ONE;
    end

    cap_d = cap_q;
    if (cap_evt)     cap_d = cnt_q;
    else if (wr_cap) cap_d = wdata;

    status_d = status_q;
    if (irq_cap)       status_d = 1'b1;
    else if (irq_wrap) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q   <= '0;
      status_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
      cap_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
      lim_q    <= lim_d;
      cap_q    <= cap_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    unique case (addr)
      REG_CTRL:  rdata = CNT_W'({status_q, ctrl_q});
      REG_COUNT: rdata = cnt_q;
      REG_LIMIT: rdata = lim_q;
      default:   rdata = cap_q;
    endcase
  end

  assign irq = irq_q;

  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_s)
    cap_evt |=> cap_q == $past(cnt_q));

  a_r6_restart_to_one: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_evt && ctrl_q.restart) |=> cnt_q == ONE);

  a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rst_s)
    (cap_evt && wrap_evt && cap_ok) |=> (irq_q && status_q));

  a_r11_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_s)
    (!ctrl_q.en && !wr_cnt) |=> $stable(cnt_q));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_s)
    irq_q |-> $past(ctrl_q.en));
endmodule

// File: tb/test_cap_timer.sv
module test_cap_timer;
  localparam int CLK_PER = 10;
  localparam int NV = 5;
  localparam int V_PS  [NV] = '{3, 0, 2, 7, 1};
  localparam int V_LIM [NV] = '{5, 4, 3, 2, 10};
  localparam int V_EXP [NV] = '{40, 4, 12, 256, 20};

  logic        clk = 1'b0;
  logic        rst_n, wr_en, tmr_in;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        irq;
  int          checks = 0, errs = 0;
  logic        done = 1'b0;

  cap_timer i_cap_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_in(tmr_in), .irq(irq));

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [15:0] mk(input logic en, input logic rs, input logic fall,
                                     input logic [2:0] ps, input logic [1:0] src);
    return {8'h00, src, ps, fall, rs, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (irq) begin n = i; break; end
    end
  endtask

  task automatic count_irqs(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (irq) k++; end
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c, c2;
    int n, k;
    rst_n = 1'b0; wr_en = 1'b0; tmr_in = 1'b0; addr = 2'd0; wdata = '0;
    cycles(3); rst_n = 1'b1; cycles(3);

    // R1 reset state
    check("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 reg", v, 0); end

    // R2/R3/R11 table: latency from enable and period between reloads
    for (int t = 0; t < NV; t++) begin
      wr(2'd0, mk(0, 0, 0, 3'(V_PS[t]), 2'd0));
      wr(2'd1, 16'd1);
      wr(2'd2, 16'(V_LIM[t]));
      wr(2'd0, mk(1, 0, 0, 3'(V_PS[t]), 2'd0));
      wait_irq(n); check("R11 first reload latency", n, V_EXP[t]);
      rd(2'd1, v); check("R3 wrap to 0001", v, 1);
      wait_irq(n); check("R2 reload period", n, V_EXP[t]);
    end

    // R11 frozen when disabled, R10 write taken when disabled
    wr(2'd0, mk(0, 0, 0, 0, 0));
    rd(2'd1, c); cycles(5); rd(2'd1, v); check("R11 count holds", v, c);
    wr(2'd1, 16'h0042); rd(2'd1, v); check("R10 write when off", v, 16'h0042);

    // R5/R6/R9 continue-mode capture
    wr(2'd1, 16'd1); wr(2'd2, 16'hFFFF); wr(2'd3, 16'h0000);
    wr(2'd0, mk(1, 0, 0, 0, 0));
    rd(2'd1, c); tmr_in = 1'b1;
    cycles(2); check("R9 no early irq", irq, 0);
    cycles(1); check("R9 irq pulse", irq, 1);
    rd(2'd3, v); check("R5 capture value", v, c + 16'd2);
    rd(2'd1, v); check("R6 continue counting", v, c + 16'd3);
    rd(2'd0, v); check("R7 status on capture", v[8], 1);
    cycles(1); check("R9 single cycle", irq, 0);

    // R10 count write ignored while enabled
    wr(2'd1, 16'hABCD); rd(2'd1, v); check("R10 write ignored", v < 16'h0100, 1);

    // R4 falling polarity
    wr(2'd0, mk(1, 0, 1, 0, 0)); cycles(3);
    rd(2'd1, c); tmr_in = 1'b0; cycles(3);
    check("R4 falling irq", irq, 1);
    rd(2'd3, v); check("R4 falling capture", v, c + 16'd2);
    tmr_in = 1'b1; count_irqs(6, k); check("R4 rising ignored irq", k, 0);
    rd(2'd3, c2); check("R4 rising ignored capture", c2, v);

    // R6 restart mode
    wr(2'd0, mk(1, 1, 0, 0, 0));
    tmr_in = 1'b0; count_irqs(5, k); check("R4 falling ignored in rising mode", k, 0);
    rd(2'd1, c); tmr_in = 1'b1; cycles(3);
    check("R9 restart irq", irq, 1);
    rd(2'd3, v); check("R5 restart capture", v, c + 16'd2);
    rd(2'd1, v); check("R6 restart to 0001", v, 1);
    cycles(1); rd(2'd1, v); check("R6 resume after restart", v, 2);

    // R7 reload interrupt clears status
    wr(2'd0, mk(0, 0, 0, 0, 0)); wr(2'd1, 16'd1); wr(2'd2, 16'd4);
    wr(2'd0, mk(1, 0, 0, 0, 0));
    wait_irq(n); rd(2'd0, v); check("R7 status cleared by reload", v[8], 0);

    // R8 capture-only filter
    tmr_in = 1'b0;
    wr(2'd0, mk(1, 0, 0, 0, 2'd1));
    count_irqs(30, k); check("R8 reloads filtered", k, 0);
    tmr_in = 1'b1; cycles(3); check("R8 capture passes", irq, 1);
    count_irqs(30, k); check("R8 reloads still filtered", k, 0);
    rd(2'd0, v); check("R8 status kept", v[8], 1);

    // R8 reload-only filter: capture latches, no irq
    wr(2'd0, mk(0, 0, 0, 0, 2'd2)); wr(2'd1, 16'd1); wr(2'd2, 16'hFFFF);
    tmr_in = 1'b0;
    wr(2'd0, mk(1, 0, 0, 0, 2'd2)); cycles(2);
    rd(2'd1, c); tmr_in = 1'b1; count_irqs(6, k);
    check("R8 capture filtered", k, 0);
    rd(2'd3, v); check("R8 filtered capture latched", v, c + 16'd2);

    // R7 simultaneous capture and reload
    tmr_in = 1'b0;
    wr(2'd0, mk(0, 0, 0, 0, 0)); wr(2'd1, 16'd1); wr(2'd2, 16'd3);
    wr(2'd0, mk(1, 0, 0, 0, 0));
    wait_irq(n); rd(2'd0, v); check("R7 status zero before", v[8], 0);
    wr(2'd0, mk(0, 0, 0, 0, 0)); wr(2'd1, 16'd1); wr(2'd3, 16'h0000);
    wr(2'd0, mk(1, 0, 0, 0, 0));
    tmr_in = 1'b1; cycles(3);
    check("R7 simultaneous irq", irq, 1);
    rd(2'd0, v); check("R7 capture wins", v[8], 1);
    rd(2'd3, v); check("R7 captured at limit", v, 3);
    rd(2'd1, v); check("R3 wrapped on same edge", v, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule